// File: doc/BRIEF.md
# Presettable Two-Section Ripple Counter

This block is a four-bit counter made of two sections, each with its own clock. The low section is one flip-flop that divides its clock by two. The high section is three flip-flops. The `DECADE` parameter sets how far the high section counts: it divides by five when the parameter is set, and by eight when it is clear. Each section advances on the falling edge of its own clock. The high section keeps its three flip-flops in step with each other. Between the two sections there is no connection inside the block, so the user chains them from outside.

In the decade build, two chainings are useful. Wiring the low output to the high clock gives a plain BCD count. Wiring the top output bit to the low clock gives a bi-quinary count, in which the low bit becomes a square wave at one tenth of the input rate. In the binary build, wiring the low output to the high clock gives a count modulo sixteen.

Two active-low controls act without a clock. The clear input empties all four flip-flops and wins over everything else. The preset input makes the outputs copy the four data inputs while it is held low. When preset is released, the last data value stays in the flip-flops. This lets the block start counting from any value, or serve as a simple four-bit latch.

Top module: `twoSecRippleCounter`

## Requirements
- R1: Each falling edge of `clkLo` inverts `cntOut[0]` when neither control is active.
- R2: While `rstAllN` is low, `cntOut` is 0 at once, with no clock needed, and clock edges have no effect.
- R3: When `rstAllN` and `presetN` are both low, `cntOut` is 0 whatever `presetData` holds.
- R4: While `presetN` is low and `rstAllN` is high, `cntOut` equals `presetData` bit for bit and follows every change of it. Clock edges on either input have no effect.
- R5: In the decade build, each falling edge of `clkHi` moves `cntOut[3:1]`, read as a binary number with `cntOut[1]` as its LSB, through 0,1,2,3,4 and then back to 0.
- R6: In the decade build, a high-section value of 5, 6 or 7 goes to 0 on the next falling edge of `clkHi`.
- R7: Decade build with `cntOut[0]` wired to `clkHi`: after n falling edges of `clkLo` from zero, `cntOut` read as binary equals n mod 10.
- R8: Decade build with `cntOut[3]` wired to `clkLo`: after n falling edges of `clkHi` from zero, `cntOut[3:1]` is n mod 5 and `cntOut[0]` is (n/5) mod 2. Over any ten input edges, `cntOut[0]` is high for exactly five.
- R9: In the binary build, the high section counts 0 to 7 and wraps. With `cntOut[0]` wired to `clkHi`, `cntOut` after n falling edges of `clkLo` equals (start + n) mod 16.
- R10: When `presetN` rises, `cntOut` keeps the last value of `presetData`. Later changes of `presetData` do not alter it.
- R11: After a preset is released, counting continues from the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkLo | input | 1 | Clock of the divide-by-two section, active on the falling edge |
| clkHi | input | 1 | Clock of the three-bit section, active on the falling edge |
| rstAllN | input | 1 | Active-low asynchronous clear, highest priority |
| presetN | input | 1 | Active-low asynchronous load of `presetData` |
| presetData | input | 4 | Value to load; bit 0 goes to the low section |
| cntOut | output | 4 | Flip-flop states; bit 0 is the low section, bits 3:1 the high section |

## Verification
Each flip-flop is visible directly at `cntOut`, so a wrong state shows up at the ports as soon as the clock edge that produced it has passed. A bad next-state value in the high section appears as a skipped or repeated step in the chained sequences. The same fault also leaves a value above 4 in the decade build, and an invalid value that fails to return to 0 is seen on the very next `clkHi` edge. A clock edge that leaks through while a control is active shows up as an output that differs from 0 or from `presetData` before the control is released. A faulty hold shows up as an output that changes when `presetData` moves after release.

// File: rtl/twoSecPkg.sv
package twoSecPkg;
  localparam int CNT_BITS = 4;
  localparam int HI_BITS  = CNT_BITS - 1;

  typedef struct packed {
    logic [CNT_BITS-1:0] setN;
    logic [CNT_BITS-1:0] clrN;
  } presetStrb_t;
endpackage

// File: rtl/twoSecPresetCtrl.sv
module twoSecPresetCtrl
  import twoSecPkg::*;
(
  input  logic                rstAllN,
  input  logic                presetN,
  input  logic [CNT_BITS-1:0] presetData,
  output presetStrb_t         strb
);
  // Per-bit asynchronous set/clear levels; clear dominates set.
  always_comb begin
    for (int i = 0; i < CNT_BITS; i++) begin
      strb.clrN[i] = rstAllN & (presetN | presetData[i]);
      strb.setN[i] = ~(rstAllN & ~presetN & presetData[i]);
    end
  end
endmodule

// File: rtl/twoSecHiNext.sv
module twoSecHiNext
  import twoSecPkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  logic [HI_BITS-1:0] cur,
  output logic [HI_BITS-1:0] nxt
);
  localparam int HI_MOD = DECADE ? 5 : (1 << HI_BITS);
  localparam logic [HI_BITS-1:0] HI_LAST = HI_BITS'(HI_MOD - 1);

  // Any value at or above the last legal state returns to zero.
  always_comb begin
    if (cur >= HI_LAST) nxt = '0;
    else                nxt = cur + 1'b1;
  end
endmodule

// File: rtl/twoSecBitCell.sv
module twoSecBitCell (
  input  logic clkN,
  input  logic clrN,
  input  logic setN,
  input  logic d,
  output logic q
);
  always_ff @(negedge clkN or negedge clrN or negedge setN) begin
    if (!clrN)      q <= 1'b0;
    else if (!setN) q <= 1'b1;
    else            q <= d;
  end
endmodule

// File: rtl/twoSecDatapath.sv
module twoSecDatapath
  import twoSecPkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  logic                clkLo,
  input  logic                clkHi,
  input  presetStrb_t         strb,
  output logic [CNT_BITS-1:0] state
);
  logic [CNT_BITS-1:0] clrN;
  logic [CNT_BITS-1:0] setN;
  logic [HI_BITS-1:0]  hiNext;

  assign clrN = strb.clrN;
  assign setN = strb.setN;

  twoSecHiNext #(.DECADE(DECADE)) hiNext_i (
    .cur (state[CNT_BITS-1:1]),
    .nxt (hiNext)
  );

  // Divide-by-two section.
  twoSecBitCell loCell_i (
    .clkN (clkLo),
    .clrN (clrN[0]),
    .setN (setN[0]),
    .d    (~state[0]),
    .q    (state[0])
  );

  // High section: all bits share clkHi.
  for (genvar i = 1; i < CNT_BITS; i++) begin : g_hiBit
    twoSecBitCell hiCell_i (
      .clkN (clkHi),
      .clrN (clrN[i]),
      .setN (setN[i]),
      .d    (hiNext[i-1]),
      .q    (state[i])
    );
  end
endmodule

// File: rtl/twoSecRippleCounter.sv
module twoSecRippleCounter
  import twoSecPkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input  logic                clkLo,
  input  logic                clkHi,
  input  logic                rstAllN,
  input  logic                presetN,
  input  logic [CNT_BITS-1:0] presetData,
  output logic [CNT_BITS-1:0] cntOut
);
  presetStrb_t strb;

  twoSecPresetCtrl ctrl_i (
    .rstAllN    (rstAllN),
    .presetN    (presetN),
    .presetData (presetData),
    .strb       (strb)
  );

  twoSecDatapath #(.DECADE(DECADE)) dp_i (
    .clkLo (clkLo),
    .clkHi (clkHi),
    .strb  (strb),
    .state (cntOut)
  );
endmodule

// File: rtl/twoSecCheck.sv
module twoSecCheck
  import twoSecPkg::*;
#(
  parameter bit DECADE = 1'b1
) (
  input logic                clkLo,
  input logic                clkHi,
  input logic                rstAllN,
  input logic                presetN,
  input logic [CNT_BITS-1:0] presetData,
  input logic [CNT_BITS-1:0] cntOut
);
  localparam int HI_MOD = DECADE ? 5 : (1 << HI_BITS);
  localparam logic [HI_BITS-1:0] HI_LAST = HI_BITS'(HI_MOD - 1);

  logic               loValid, hiValid;
  logic               loPrev;
  logic [HI_BITS-1:0] hiPrev, hiExp;

  always_ff @(negedge clkLo or negedge rstAllN or negedge presetN) begin
    if (!rstAllN)      loValid <= 1'b0;
    else if (!presetN) loValid <= 1'b0;
    else begin
      loValid <= 1'b1;
      loPrev  <= cntOut[0];
    end
  end

  always_ff @(negedge clkHi or negedge rstAllN or negedge presetN) begin
    if (!rstAllN)      hiValid <= 1'b0;
    else if (!presetN) hiValid <= 1'b0;
    else begin
      hiValid <= 1'b1;
      hiPrev  <= cntOut[CNT_BITS-1:1];
    end
  end

  always_comb begin
    if (hiPrev >= HI_LAST) hiExp = '0;
    else                   hiExp = hiPrev + 1'b1;
  end

  // R1
  lo_toggle_chk: assert property (@(negedge clkLo) disable iff (!rstAllN || !presetN)
    loValid |-> (cntOut[0] != loPrev));

  // R5
  hi_step_chk: assert property (@(negedge clkHi) disable iff (!rstAllN || !presetN)
    hiValid |-> (cntOut[CNT_BITS-1:1] == hiExp));

  // R6
  hi_range_chk: assert property (@(negedge clkHi) disable iff (!rstAllN || !presetN)
    hiValid |-> (cntOut[CNT_BITS-1:1] <= HI_LAST));

  always @(negedge clkLo) begin
    // R2
    if (!rstAllN) clear_zero_chk: assert (cntOut == '0);
    // R4
    if (rstAllN && !presetN) load_follow_chk: assert (cntOut == presetData);
  end
endmodule

bind twoSecRippleCounter twoSecCheck #(.DECADE(DECADE)) chk_i (
  .clkLo      (clkLo),
  .clkHi      (clkHi),
  .rstAllN    (rstAllN),
  .presetN    (presetN),
  .presetData (presetData),
  .cntOut     (cntOut)
);

// File: tb/twoSecRippleCounter_tb.sv
module twoSecRippleCounter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 200000;

  logic       rstAllN    = 1'b0;
  logic       presetN    = 1'b1;
  logic [3:0] presetData = 4'h0;
  logic       extLo      = 1'b1;
  logic       extHi      = 1'b1;
  int         mode       = 0; // 0 free, 1 BCD, 2 bi-quinary, 3 binary
  int         checks     = 0;
  int         fails      = 0;
  bit         done       = 1'b0;

  logic [3:0] cntOut, binOut;
  logic       clkLoW, clkHiW, clkLoB;

  assign clkLoW = (mode == 2) ? cntOut[3] : extLo;
  assign clkHiW = (mode == 1) ? cntOut[0] : extHi;
  assign clkLoB = (mode == 3) ? extLo : 1'b1;

  twoSecRippleCounter #(.DECADE(1'b1)) dut_i (
    .clkLo (clkLoW), .clkHi (clkHiW), .rstAllN (rstAllN),
    .presetN (presetN), .presetData (presetData), .cntOut (cntOut)
  );

  twoSecRippleCounter #(.DECADE(1'b0)) dutBin_i (
    .clkLo (clkLoB), .clkHi (binOut[0]), .rstAllN (rstAllN),
    .presetN (presetN), .presetData (presetData), .cntOut (binOut)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseLo();
    extLo = 1'b0; #(CLK_PERIOD/2);
    extLo = 1'b1; #(CLK_PERIOD/2);
  endtask

  task automatic pulseHi();
    extHi = 1'b0; #(CLK_PERIOD/2);
    extHi = 1'b1; #(CLK_PERIOD/2);
  endtask

  task automatic setMode(input int m);
    rstAllN = 1'b0; #(CLK_PERIOD);
    mode = m;       #(CLK_PERIOD);
    rstAllN = 1'b1; #(CLK_PERIOD);
  endtask

  task automatic testReset();
    rstAllN = 1'b0; #(CLK_PERIOD);
    pulseLo(); pulseHi();
    check("R2 reset state", cntOut, 4'h0);
    check("R2 reset state binary", binOut, 4'h0);
    rstAllN = 1'b1; #(CLK_PERIOD);
  endtask

  task automatic testFree();
    setMode(0);
    for (int n = 1; n <= 3; n++) begin
      pulseLo();
      check("R1 low toggle", cntOut, {3'd0, 1'(n % 2)});
    end
    for (int n = 1; n <= 12; n++) begin
      pulseHi();
      check("R5 decade high step", cntOut, {3'(n % 5), 1'b1});
    end
  endtask

  task automatic testBcd();
    setMode(1);
    for (int n = 1; n <= 20; n++) begin
      pulseLo();
      check("R7 BCD count", cntOut, 4'(n % 10));
    end
  endtask

  task automatic testBiq();
    int highs = 0;
    setMode(2);
    for (int n = 1; n <= 20; n++) begin
      pulseHi();
      if (n <= 10 && cntOut[0]) highs++;
      check("R8 bi-quinary count", cntOut, {3'(n % 5), 1'((n / 5) % 2)});
    end
    check("R8 low half duty", 4'(highs), 4'd5);
  endtask

  task automatic testBinary();
    setMode(3);
    for (int n = 1; n <= 32; n++) begin
      pulseLo();
      check("R9 binary count", binOut, 4'(n % 16));
    end
    presetData = 4'hA; presetN = 1'b0; #(CLK_PERIOD);
    presetN = 1'b1; #(CLK_PERIOD);
    pulseLo(); check("R9 binary from load", binOut, 4'hB);
    pulseLo(); check("R9 binary from load", binOut, 4'hC);
  endtask

  task automatic testLoadCount();
    setMode(1);
    for (int n = 0; n < 3; n++) pulseLo();
    check("R7 BCD before load", cntOut, 4'h3);
    presetData = 4'h7; presetN = 1'b0; #(CLK_PERIOD);
    check("R4 load value", cntOut, 4'h7);
    pulseLo();
    check("R4 clock ignored in load", cntOut, 4'h7);
    presetN = 1'b1; #(CLK_PERIOD);
    check("R10 value held", cntOut, 4'h7);
    pulseLo(); check("R11 count from load", cntOut, 4'h8);
    pulseLo(); check("R11 count from load", cntOut, 4'h9);
    pulseLo(); check("R11 count from load", cntOut, 4'h0);
    pulseLo(); check("R11 count from load", cntOut, 4'h1);
  endtask

  task automatic testLatch();
    logic [3:0] vals [6] = '{4'h5, 4'hA, 4'h3, 4'hF, 4'h0, 4'h9};
    setMode(0);
    presetN = 1'b0;
    for (int k = 0; k < 6; k++) begin
      presetData = vals[k]; #(CLK_PERIOD);
      check("R4 output follows data", cntOut, vals[k]);
    end
    pulseHi();
    check("R4 high clock ignored in load", cntOut, 4'h9);
    presetN = 1'b1; #(CLK_PERIOD);
    check("R10 latch holds", cntOut, 4'h9);
    presetData = 4'h6; #(CLK_PERIOD);
    check("R10 data ignored after release", cntOut, 4'h9);
  endtask

  task automatic testResetMid();
    setMode(1);
    for (int n = 0; n < 6; n++) pulseLo();
    check("R7 BCD mid count", cntOut, 4'h6);
    rstAllN = 1'b0; #(CLK_PERIOD);
    check("R2 reset mid count", cntOut, 4'h0);
    pulseLo();
    check("R2 clock ignored in reset", cntOut, 4'h0);
    presetData = 4'hF; presetN = 1'b0; #(CLK_PERIOD);
    check("R3 reset beats preset", cntOut, 4'h0);
    rstAllN = 1'b1; #(CLK_PERIOD);
    check("R4 preset after reset release", cntOut, 4'hF);
    presetN = 1'b1; #(CLK_PERIOD);
    pulseLo();
    check("R6 invalid 7 recovers in chain", cntOut, 4'h0);
  endtask

  task automatic testInvalid();
    setMode(0);
    for (int v = 5; v <= 7; v++) begin
      presetData = {3'(v), 1'b0}; presetN = 1'b0; #(CLK_PERIOD);
      presetN = 1'b1; #(CLK_PERIOD);
      pulseHi();
      check("R6 invalid state recovery", cntOut, 4'h0);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    #(CLK_PERIOD);
    check("R2 reset at start", cntOut, 4'h0);
    rstAllN = 1'b1; #(CLK_PERIOD);
    testReset();
    testFree();
    testBcd();
    testBiq();
    testBinary();
    testLoadCount();
    testLatch();
    testResetMid();
    testInvalid();
    if (!done) begin
      done = 1'b1;
      finishRun();
    end
  end
endmodule